// File: doc/BRIEF.md
# Rate-Half Serial Convolutional Encoder

This block turns a serial stream of information bits into a stream of two-bit code symbols. Every accepted bit yields exactly one symbol. The symbol is formed from a three-bit window: the new bit and the two bits accepted just before it. The first code bit is the parity of all three window positions (generator 111). The second code bit is the parity of the newest and oldest positions (generator 101). The two older bits form the encoder state, so the trellis has four states.

Frames are marked by the producer on their final data bit. After that bit, the block feeds two zero bits into the shift register on its own, which drives the state back to zero. It emits the two matching tail symbols and flags the second of them as the end of the frame. The next frame therefore always starts from the all-zero state.

Both edges use a ready/valid handshake. When the consumer stalls, the pending symbol is held and the shift register does not move.

Top module: `conv_half_enc`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1 and the shift register state is all zeros.
- R2: out_code[1] equals the XOR of the accepted bit and the two bits accepted before it in the same frame (generator 111), with the missing older bits taken as 0 at frame start.
- R3: out_code[0] equals the XOR of the accepted bit and the bit accepted two steps earlier (generator 101).
- R4: Each accepted bit enters the newest register position while the older bits move one position toward the oldest, so symbols come out in the same order as the bits were accepted.
- R5: A bit accepted with in_last set is followed by exactly two tail symbols, each encoded from a zero input bit, so a frame of N bits gives N+2 symbols.
- R6: in_ready is 0 from the cycle after the in_last bit is accepted until the second tail symbol has been loaded.
- R7: out_last is 1 on the second tail symbol of each frame and 0 on every other symbol.
- R8: After the tail, the state is all zeros, so the first symbol of the next frame depends only on its first bit (1 gives code 11, 0 gives code 00).
- R9: While out_valid is 1 and out_ready is 0, out_code and out_last hold their values, out_valid stays 1, and in_ready is 0.
- R10: With out_ready held at 1 and a bit offered every cycle, one symbol is presented per cycle, with no gaps.
- R11: The input bits 1,1,0,1,1 (the last one carrying in_last) give the symbol sequence 11, 01, 01, 00, 01, 01, 11, written as out_code[1] then out_code[0].
- R12: A cycle with in_valid at 0 does not change the state: the bits offered during such cycles have no effect on later symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An information bit is offered |
| in_ready | output | 1 | The block accepts the offered bit this cycle |
| in_bit | input | 1 | Information bit |
| in_last | input | 1 | The offered bit is the last of its frame |
| out_valid | output | 1 | A code symbol is presented |
| out_ready | input | 1 | The consumer takes the symbol this cycle |
| out_code | output | 2 | Code symbol; bit 1 is the 111 parity, bit 0 is the 101 parity |
| out_last | output | 1 | The symbol is the final tail symbol of a frame |

## Verification
A corrupted state bit does not stay hidden. It changes the parity of the next symbol, or of the symbol after it, because every state bit appears in at least one of the two generators within two accepted bits. A tail that leaves residue behind shows up on the first symbol of the following frame. A symbol that moves or a register that steps during a stall is visible within one cycle, because the held symbol changes or because later symbols no longer match the model's bit order.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int CL       = 3;
    localparam int NSYM     = 2;
    localparam int SW       = CL - 1;
    localparam int TAIL_LEN = CL - 1;
    localparam int TAIL_CW  = $clog2(TAIL_LEN + 1);

    // index NSYM-1 is emitted as the first code bit; window MSB is the newest bit
    localparam logic [NSYM-1:0][CL-1:0] GENS = {3'b111, 3'b101};

    typedef logic [SW-1:0]      state_t;
    typedef logic [NSYM-1:0]    code_t;
    typedef logic [TAIL_CW-1:0] tcnt_t;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_TAIL = 1'b1
    } phase_t;

    typedef struct packed {
        logic  last;
        code_t code;
    } sym_t;

    function automatic logic [CL-1:0] make_window(logic b, state_t s);
        return {b, s};
    endfunction

    function automatic state_t next_state(logic [CL-1:0] w);
        return w[CL-1:1];
    endfunction

endpackage

// File: rtl/conv_state_reg.sv
module conv_state_reg
    import conv_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         bit_in,
    output state_t       state_q,
    output logic [CL-1:0] window
);

    assign window = make_window(bit_in, state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (step) begin
            state_q <= next_state(window);
        end
    end

    p_newest_enters_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> state_q[SW-1] == $past(bit_in));

    p_idle_keeps_state_r12: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));

endmodule

// File: rtl/conv_tail_ctrl.sv
module conv_tail_ctrl
    import conv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  logic   accept_last,
    output phase_t phase_q,
    output logic   tail_step,
    output logic   tail_final
);

    tcnt_t cnt_q;

    assign tail_step  = (phase_q == PH_TAIL) && advance;
    assign tail_final = (phase_q == PH_TAIL) && (cnt_q == tcnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_DATA: if (accept_last) begin
                    phase_q <= PH_TAIL;
                    cnt_q   <= tcnt_t'(TAIL_LEN);
                end
                PH_TAIL: if (advance) begin
                    cnt_q <= cnt_q - tcnt_t'(1);
                    if (cnt_q == tcnt_t'(1)) phase_q <= PH_DATA;
                end
                default: phase_q <= PH_DATA;
            endcase
        end
    end

    p_tail_count_live_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL) |-> (cnt_q != '0));

    p_last_opens_tail_r6: assert property (@(posedge clk) disable iff (rst)
        accept_last |=> (phase_q == PH_TAIL));

endmodule

// File: rtl/conv_sym_out.sv
module conv_sym_out
    import conv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  sym_t d,
    input  logic out_ready,
    output logic out_valid,
    output sym_t q,
    output logic advance
);

    assign advance = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (advance) begin
            out_valid <= load;
            if (load) q <= d;
        end
    end

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(q)));

endmodule

// File: rtl/conv_half_enc.sv
module conv_half_enc
    import conv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [1:0] out_code,
    output logic       out_last
);

    phase_t        phase;
    logic          advance, tail_step, tail_final;
    logic          accept, step, feed_bit;
    state_t        state;
    logic [CL-1:0] window;
    code_t         code;
    sym_t          sym_d, sym_q;

    assign in_ready = advance && (phase == PH_DATA);
    assign accept   = in_valid && in_ready;
    assign step     = accept || tail_step;
    assign feed_bit = (phase == PH_TAIL) ? 1'b0 : in_bit;

    conv_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .bit_in  (feed_bit),
        .state_q (state),
        .window  (window)
    );

    conv_tail_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .accept_last (accept && in_last),
        .phase_q     (phase),
        .tail_step   (tail_step),
        .tail_final  (tail_final)
    );

    for (genvar k = 0; k < NSYM; k++) begin : g_tap
        assign code[k] = ^(window & GENS[k]);
    end

    assign sym_d.code = code;
    assign sym_d.last = tail_step && tail_final;

    conv_sym_out u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (step),
        .d         (sym_d),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .q         (sym_q),
        .advance   (advance)
    );

    assign out_code = sym_q.code;
    assign out_last = sym_q.last;

    p_flush_to_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (tail_step && tail_final) |=> (state == '0));

    p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_tail_blocks_input_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |-> !in_ready);

endmodule

// File: tb/conv_half_enc_tb.sv
module conv_half_enc_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready, in_bit, in_last;
    logic       out_valid, out_ready, out_last;
    logic [1:0] out_code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    conv_half_enc u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .out_last(out_last)
    );

    // reference: m1 = bit accepted one step ago, m2 = two steps ago
    logic m1 = 0, m2 = 0;
    logic [2:0] expq[$];

    function automatic logic [1:0] ref_code(logic b, logic a1, logic a2);
        return {b ^ a1 ^ a2, b ^ a2};
    endfunction

    task automatic push_bit(logic b, logic lst);
        expq.push_back({lst, ref_code(b, m1, m2)});
        m2 = m1;
        m1 = b;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // directed frame with out_ready fixed at 1; checks every output cycle
    task automatic directed(input logic bits[], input logic [1:0] exp[]);
        int n = bits.size();
        for (int c = 0; c <= n + 2; c++) begin
            @(negedge clk);
            out_ready = 1;
            in_valid  = (c < n);
            in_bit    = (c < n) ? bits[c] : 1'b0;
            in_last   = (c == n - 1);
            #1;
            if (c >= n && c <= n + 1)
                check(in_ready == 0, "R6 in_ready during tail", in_ready, 0);
            if (c >= 1) begin
                check(out_valid == 1, "R10 symbol every cycle", out_valid, 1);
                check(out_code == exp[c-1], "R11 known sequence", out_code, exp[c-1]);
                check(out_last == (c == n + 2), "R7 out_last position", out_last, c == n + 2);
            end
        end
        @(negedge clk);
        in_valid = 0;
        #1;
        check(out_valid == 0, "R5 no extra symbol after tail", out_valid, 0);
    endtask

    initial begin
        int hold_pend = 0;
        logic [2:0] held = '0;
        int tails = 0;
        logic [2:0] e;
        process::self().srandom(32'd7);
        rst = 1; in_valid = 0; in_bit = 0; in_last = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

        directed('{1, 1, 0, 1, 1}, '{2'b11, 2'b01, 2'b01, 2'b00, 2'b01, 2'b01, 2'b11});
        // R8: fresh frame after a tail starts from zero state
        directed('{1}, '{2'b11, 2'b10, 2'b11});
        directed('{0, 1}, '{2'b00, 2'b11, 2'b10, 2'b11});

        // random traffic against the reference model
        m1 = 0; m2 = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            in_valid  = ($urandom % 3) != 0;
            in_bit    = $urandom % 2;
            in_last   = ($urandom % 9) == 0;
            #1;
            if (hold_pend != 0) begin
                check(out_valid == 1 && {out_last, out_code} == held, "R9 stalled symbol held",
                      {out_valid, out_last, out_code}, {1'b1, held});
            end
            if (out_valid && !out_ready) begin
                check(in_ready == 0, "R9 no input while stalled", in_ready, 0);
                hold_pend = 1; held = {out_last, out_code};
            end else hold_pend = 0;
            if (tails > 0)
                check(in_ready == 0, "R6 in_ready during tail", in_ready, 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R5 unexpected symbol", {out_last, out_code}, 0);
                end else begin
                    e = expq.pop_front();
                    check(out_code == e[1:0], "R2/R3/R4/R12 code", out_code, e[1:0]);
                    check(out_last == e[2], "R7 out_last", out_last, e[2]);
                end
            end
            if (tails > 0) begin
                if (!out_valid || out_ready) begin
                    tails--;
                    push_bit(0, tails == 0);
                end
            end else if (in_valid && in_ready) begin
                push_bit(in_bit, 0);
                if (in_last) tails = 2;
            end
        end
        // drain
        in_valid = 0;
        for (int cyc = 0; cyc < 20; cyc++) begin
            @(negedge clk);
            out_ready = 1;
            #1;
            if (tails > 0 && (!out_valid || out_ready)) begin
                // tail loaded at this edge; model it before comparing later symbols
            end
            if (out_valid) begin
                if (expq.size() != 0) begin
                    e = expq.pop_front();
                    check(out_code == e[1:0], "R2/R3 code drain", out_code, e[1:0]);
                    check(out_last == e[2], "R7 out_last drain", out_last, e[2]);
                end
            end
            if (tails > 0) begin
                tails--;
                push_bit(0, tails == 0);
            end
        end
        check(expq.size() == 0, "R5 all symbols delivered", expq.size(), 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

endmodule